// File: doc/BRIEF.md
# SAR Converter Result Register and Byte-Wide Read Port

This block is the digital back end of a 12-bit successive-approximation converter. A write strobe starts a conversion. The sequencer then spends a fixed number of clock cycles on settling and auto-zero. After that it takes one comparator decision per clock, most significant bit first.

The decisions feed an output register that runs in one of two modes, chosen by a runtime mode input. In transparent mode, each decision shows up in the output register on the clock edge that makes it. In hold mode, the register is loaded only when the last decision is made, and the previous result stays readable while the next conversion runs.

A host reads the result as two bytes over an 8-bit bus. It uses active-low chip select, read and write lines, and a high-byte-enable line chooses the byte. The high byte carries a conversion-in-progress flag in bit 7. The bus is released whenever no read strobe is active. Release is shown by a separate output-enable, and the data lines are forced to zero while released.

Top module: `sar_result_port`

## Requirements
- R1: After reset, `idle` is 1, `data_oe` is 0, and both bytes of the result read as zero with the status flag clear.
- R2: With `hold_mode` low, starting a conversion clears the output register. Each decision is copied into its bit of the output register on the clock edge that makes it, so undecided bits read 0.
- R3: A conversion starts on the first rising clock edge that sees a new write strobe while idle. Five settle edges follow. Bit 11 is decided on the 6th edge after the start edge, bit 8 on the 9th, and bit 0 on the 17th. `idle` is low from the start edge until the 17th edge, then returns high.
- R4: A write strobe while a conversion runs is ignored. The conversion finishes on its original schedule with an unchanged result. A new start needs the write strobe to be released and asserted again.
- R5: With `hold_mode` high, the output register changes only on the edge that decides bit 0, when it takes the full new result. During the following conversion, reads return the previous result.
- R6: With `hbe` high during a read, `data_out` is {flag, 3'b000, result[11:8]}. The flag in bit 7 is 1 while a conversion runs and 0 when idle.
- R7: With `hbe` low during a read, `data_out` is result[7:0]. The byte shown follows `hbe` combinationally within a single read.
- R8: `data_oe` is 1 exactly when `cs_n` and `rd_n` are both low. While `data_oe` is 0, `data_out` is all zeros.
- R9: A low `wr_n` with `cs_n` high does not start a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read |
| wr_n | input | 1 | Active-low write; with `cs_n` starts a conversion |
| hbe | input | 1 | High-byte enable: 1 selects status and upper bits, 0 the lower byte |
| hold_mode | input | 1 | Output register mode: 0 transparent, 1 hold until complete |
| cmp_in | input | 1 | Comparator decision for the bit under test |
| data_out | output | 8 | Read data byte, zero when released |
| data_oe | output | 1 | Bus drive enable, high during a read strobe |
| idle | output | 1 | High when no conversion is running |

## Verification
Several checks run on every clock cycle. In hold mode, the output register must not move except on the final decision. In transparent mode, each decided bit must land in the output register on the following edge. A running conversion must step through its bit index without restarting. The bus must be released whenever the read strobe is inactive, and the status bit in the high byte must always match `idle`. Only the bench scenarios can show the remaining behaviour: the exact start-to-finish edge count, the ignored mid-conversion write, the ignored write without chip select, and the actual values read back in each mode. Those scenarios include a hold-mode read that returns the previous result during a new conversion, and a transparent read that shows cleared lower bits.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_DECIDE = 2'd2
  } conv_phase_e;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_port_pkg::*;
#(
  parameter int unsigned RES_W  = 12,
  parameter int unsigned SETTLE = 5,
  localparam int unsigned MAXC  = (SETTLE > RES_W) ? SETTLE : RES_W,
  localparam int unsigned CNT_W = $clog2(MAXC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  output logic             conv,
  output logic             start,
  output logic             dec_en,
  output logic             last,
  output logic [CNT_W-1:0] dec_idx
);
  conv_phase_e      phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    start   = wr_stb && !wr_q && (phase_q == PH_IDLE);
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETTLE;
          cnt_d   = '0;
        end
      end
      PH_SETTLE: begin
        if (cnt_q == CNT_W'(SETTLE - 1)) begin
          phase_d = PH_DECIDE;
          cnt_d   = CNT_W'(RES_W - 1);
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_DECIDE: begin
        if (cnt_q == '0) phase_d = PH_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_stb;
    end
  end

  assign conv    = (phase_q != PH_IDLE);
  assign dec_en  = (phase_q == PH_DECIDE);
  assign last    = dec_en && (cnt_q == '0);
  assign dec_idx = cnt_q;

  // R4: a running decision phase only counts down, never restarts
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DECIDE) |=>
      ((phase_q == PH_DECIDE) && (cnt_q == $past(cnt_q) - 1'b1)) ||
      ((phase_q == PH_IDLE) && ($past(cnt_q) == '0)));

  // R3: the settle phase always hands over to decisions at the top bit
  a_r3_settle_to_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETTLE) |=> (phase_q == PH_SETTLE) ||
      ((phase_q == PH_DECIDE) && (cnt_q == CNT_W'(RES_W - 1))));
endmodule

// File: rtl/sar_out_reg.sv
module sar_out_reg #(
  parameter int unsigned RES_W = 12,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_mode,
  input  logic             start,
  input  logic             dec_en,
  input  logic             last,
  input  logic [CNT_W-1:0] dec_idx,
  input  logic             dec_bit,
  output logic [RES_W-1:0] result
);
  logic [RES_W-1:0] sar_q, sar_d, out_q, out_d;
  logic             sar_en, out_en;

  always_comb begin
    sar_d = sar_q;
    if (start)  sar_d = '0;
    if (dec_en) sar_d[dec_idx] = dec_bit;
    sar_en = start || dec_en;
    out_en = hold_mode ? last : sar_en;
    out_d  = out_en ? sar_d : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q <= '0;
      out_q <= '0;
    end else begin
      if (sar_en) sar_q <= sar_d;
      if (out_en) out_q <= out_d;
    end
  end

  assign result = out_q;

  // R5: hold mode leaves the visible result untouched except at completion
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mode && !last) |=> $stable(out_q));

  // R2: transparent mode shows each decision one edge later
  a_r2_track_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_mode && dec_en) |=> (out_q[$past(dec_idx)] == $past(dec_bit)));
endmodule

// File: rtl/sar_bus_rd.sv
module sar_bus_rd #(
  parameter int unsigned RES_W = 12,
  parameter int unsigned BUS_W = 8,
  localparam int unsigned HI_W = RES_W - BUS_W,
  localparam int unsigned PAD  = BUS_W - 1 - HI_W
) (
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             hbe,
  input  logic             conv,
  input  logic [RES_W-1:0] result,
  output logic [BUS_W-1:0] data,
  output logic             oe
);
  logic [BUS_W-1:0] hi_byte, lo_byte;

  always_comb begin
    oe      = !(cs_n || rd_n);
    hi_byte = {conv, {PAD{1'b0}}, result[RES_W-1 -: HI_W]};
    lo_byte = result[BUS_W-1:0];
    data    = '0;
    if (oe) data = hbe ? hi_byte : lo_byte;
  end
endmodule

// File: rtl/sar_result_port.sv
module sar_result_port #(
  parameter int unsigned RES_W  = 12,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned SETTLE = 5,
  localparam int unsigned MAXC  = (SETTLE > RES_W) ? SETTLE : RES_W,
  localparam int unsigned CNT_W = $clog2(MAXC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             hbe,
  input  logic             hold_mode,
  input  logic             cmp_in,
  output logic [BUS_W-1:0] data_out,
  output logic             data_oe,
  output logic             idle
);
  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic             wr_stb, conv, start, dec_en, last;
  logic [CNT_W-1:0] dec_idx;
  logic [RES_W-1:0] result;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign wr_stb = !(cs_n || wr_n);

  sar_seq_ctrl #(.RES_W(RES_W), .SETTLE(SETTLE)) u_seq (
    .clk(clk), .rst_n(rst_ni), .wr_stb(wr_stb), .conv(conv), .start(start),
    .dec_en(dec_en), .last(last), .dec_idx(dec_idx)
  );

  sar_out_reg #(.RES_W(RES_W), .CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_ni), .hold_mode(hold_mode), .start(start),
    .dec_en(dec_en), .last(last), .dec_idx(dec_idx), .dec_bit(cmp_in),
    .result(result)
  );

  sar_bus_rd #(.RES_W(RES_W), .BUS_W(BUS_W)) u_bus (
    .cs_n(cs_n), .rd_n(rd_n), .hbe(hbe), .conv(conv), .result(result),
    .data(data_out), .oe(data_oe)
  );

  assign idle = !conv;

  // R8: no read strobe means a released, zeroed bus
  a_r8_bus_release: assert property (@(posedge clk) disable iff (!rst_ni)
    (cs_n || rd_n) |-> (!data_oe && (data_out == '0)));

  // R6: status bit in the high byte mirrors the idle output
  a_r6_status_flag: assert property (@(posedge clk) disable iff (!rst_ni)
    (data_oe && hbe) |-> (data_out[BUS_W-1] == !idle));
endmodule

// File: tb/sar_result_port_test.sv
module sar_result_port_test;
  logic       clk, rst_n, cs_n, rd_n, wr_n, hbe, hold_mode, cmp_in;
  logic [7:0] data_out;
  logic       data_oe, idle;
  int         tests = 0;
  int         fails = 0;
  bit         done  = 0;
  logic [11:0] expq[$];
  logic [11:0] last_word;

  sar_result_port uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .hbe(hbe), .hold_mode(hold_mode), .cmp_in(cmp_in),
    .data_out(data_out), .data_oe(data_oe), .idle(idle)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one read cycle, toggling hbe inside it (R7), then release (R8)
  task automatic read_word(output logic [7:0] lo, output logic [7:0] hi);
    cs_n = 1'b0; rd_n = 1'b0; hbe = 1'b0;
    #1 lo = data_out;
    chk("R8 oe during read", data_oe, 1);
    hbe = 1'b1;
    #1 hi = data_out;
    cs_n = 1'b1; rd_n = 1'b1;
    #1 chk("R8 released", {data_oe, data_out}, 0);
  endtask

  // scoreboard: pop expected result and compare with what the bus returns
  task automatic sb_check();
    logic [7:0]  lo, hi;
    logic [11:0] exp;
    @(negedge clk);
    exp = expq.pop_front();
    read_word(lo, hi);
    chk("R7 low byte", lo, exp[7:0]);
    chk("R6 high byte idle", hi, {4'b0000, exp[11:8]});
    last_word = exp;
  endtask

  // driver: run one conversion, optional mid-conversion write (R4)
  task automatic convert(input logic [11:0] pat, input bit inject_wr);
    logic [7:0] lo, hi;
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0;
    @(posedge clk);
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
    #1 chk("R3 busy after start", idle, 0);
    repeat (5) @(posedge clk);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      cmp_in = pat[11-k];
      if (k == 4) begin
        read_word(lo, hi);
        if (hold_mode) begin
          chk("R5 mid low holds old", lo, last_word[7:0]);
          chk("R5 mid high holds old", hi, {4'b1000, last_word[11:8]});
        end else begin
          chk("R2 mid low cleared", lo, 8'h00);
          chk("R3 msbs after clock 9", hi, {4'b1000, pat[11:8]});
        end
      end
      if (k == 6 && inject_wr) begin cs_n = 1'b0; wr_n = 1'b0; end
      if (k == 7 && inject_wr) begin cs_n = 1'b1; wr_n = 1'b1; end
      if (k == 11) chk("R3 busy before last edge", idle, 0);
      @(posedge clk);
    end
    expq.push_back(pat);
    @(negedge clk);
    chk(inject_wr ? "R4 ends on schedule" : "R3 idle after edge 17", idle, 1);
  endtask

  initial begin
    logic [7:0] lo, hi;
    cs_n = 1; rd_n = 1; wr_n = 1; hbe = 0; hold_mode = 0; cmp_in = 0; rst_n = 0;
    last_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 idle", idle, 1);
    chk("R1 bus off", {data_oe, data_out}, 0);
    read_word(lo, hi);
    chk("R1 low zero", lo, 0);
    chk("R1 high zero", hi, 0);

    convert(12'hA5C, 0);
    sb_check();

    // R9: write without chip select
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 no start without cs", idle, 1);
    wr_n = 1'b1;

    hold_mode = 1'b1;
    convert(12'h3E7, 0);
    sb_check();
    convert(12'h81F, 1);
    sb_check();

    hold_mode = 1'b0;
    convert(12'hFFF, 0);
    sb_check();
    convert(12'h000, 1);
    sb_check();
    repeat (3) @(negedge clk);
    chk("R4 no late restart", idle, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule